// File: doc/BRIEF.md
# Countdown Watchdog with Register Access

This block is a watchdog timer that sits on a simple single-cycle register bus. Software arms it by writing a tick count into its count register. From then on the count drops by one on every tick of the chosen time base. When the count arrives at one, the block raises a reset request to the system. Software keeps the system alive by rewriting the count before that happens. A count of zero parks the timer. Because the request fires at one rather than at zero, a timeout of N ticks is programmed as N + 1, and a write of 1 restarts the system at once.

A second register holds two options. One picks which of two tick-enable inputs drives the countdown. The other freezes the timer completely. The reset request is a pulse of fixed, parameterised length, and the count returns to zero when the pulse ends. The bus reads the live count back, so software can work out the time left.

Top module: `wdt_countdown_top`

## Requirements
- R1: After power-on reset the count register and the option register both read 0 and `rst_req` is low.
- R2: The word index is `bus_addr[ADDR_W-1:2]`. Index 0 (byte address 0) is the count register and index 1 (byte address 4) is the option register. The option register keeps only bit 0 and bit DATA_W-1; all other bits read 0. Any other index reads 0, and a write to it changes nothing.
- R3: While the count is above 1 and the timer is not frozen, each selected tick lowers the count by exactly one. A cycle without a selected tick leaves it unchanged.
- R4: Option bit 0 set selects `tick_xtal` as the time base; bit 0 clear selects `tick_alt`. Pulses on the unselected input have no effect on the count.
- R5: A count of 0 is the stopped state: ticks leave it at 0 and no reset request is raised.
- R6: When the count holds 1 and the timer is not frozen, `rst_req` is high after the next clock edge. A bus write of 1 therefore gives a request two edges after the write is presented.
- R7: `rst_req` stays high for exactly PULSE_LEN cycles (default 4). It then drops, and the count reads 0 in the same cycle.
- R8: Option bit DATA_W-1 set freezes the timer: ticks do not change the count, and a count of 1 raises no request.
- R9: A bus write to the count register replaces the count at the next edge, even when a selected tick arrives in the same cycle. Reading the count register returns the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_addr | input | ADDR_W | Byte address of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register, combinational |
| tick_xtal | input | 1 | Tick enable from the crystal time base |
| tick_alt | input | 1 | Tick enable from the alternate time base |
| rst_req | output | 1 | System reset request pulse |

## Verification
On every cycle the assertions check the following: a parked count stays at zero, a freeze holds the count, an unfrozen count of one leads to a request, each selected tick lowers the count by exactly one, and a bus write wins over a tick. A cycle counter in the checker also confirms that every request pulse lasts exactly PULSE_LEN cycles and that the count reads zero when the pulse ends. Some behaviour shows only in the bench scenarios: the masking and decoding of the register map, which tick input actually moves the count for each option setting, and a full countdown from an armed value to a request. Two more sequences need the bench as well. One leaves a count of one under a freeze and then lifts the freeze. The other refreshes a running timer.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // word indices of the two registers (software depends on these)
   localparam int unsigned IDX_COUNT = 0;
   localparam int unsigned IDX_OPTS  = 1;

   // decoded option register
   typedef struct packed {
      logic freeze;   // stored at bit DATA_W-1
      logic use_xtal; // stored at bit 0
   } wdt_opts_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] count_q,
   output logic              count_wr,
   output wdt_opts_t         opts_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;
   logic             hit_count;
   logic             hit_opts;
   logic             unused_bits;

   assign word_idx  = bus_addr[ADDR_W-1:2];
   assign hit_count = (word_idx == IDX_W'(IDX_COUNT));
   assign hit_opts  = (word_idx == IDX_W'(IDX_OPTS));
   assign count_wr  = bus_we && hit_count;

   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-2:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opts_q <= '0;
      end else if (bus_we && hit_opts) begin
         opts_q.freeze   <= bus_wdata[DATA_W-1];
         opts_q.use_xtal <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_count) begin
         bus_rdata = count_q;
      end else if (hit_opts) begin
         bus_rdata[DATA_W-1] = opts_q.freeze;
         bus_rdata[0]        = opts_q.use_xtal;
      end
   end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wdt_opts_t         opts_q,
   input  logic              tick_xtal,
   input  logic              tick_alt,
   input  logic              count_wr,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              pulse_busy,
   input  logic              pulse_done,
   output logic [DATA_W-1:0] count_q,
   output logic              fire
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic tick_sel;
   logic can_step;

   assign tick_sel = opts_q.use_xtal ? tick_xtal : tick_alt;
   assign can_step = tick_sel && !opts_q.freeze && (count_q > ONE);
   assign fire     = (count_q == ONE) && !opts_q.freeze && !pulse_busy;

   // priority: bus write, end of request pulse, tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (count_wr) begin
         count_q <= wr_value;
      end else if (pulse_done) begin
         count_q <= '0;
      end else if (can_step) begin
         count_q <= count_q - ONE;
      end
   end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req,
   output logic done
);
   generate
      if (PULSE_LEN == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= fire;
         end
         assign req  = req_q;
         assign done = req_q;
      end else begin : g_count
         localparam int unsigned PW = $clog2(PULSE_LEN + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (fire) begin
               left_q <= PW'(PULSE_LEN);
            end else if (left_q != '0) begin
               left_q <= left_q - PW'(1);
            end
         end
         assign req  = (left_q != '0);
         assign done = (left_q == PW'(1));
      end
   endgenerate

endmodule

// File: rtl/wdt_countdown_top.sv
module wdt_countdown_top
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_xtal,
   input  logic              tick_alt,
   output logic              rst_req
);
   initial begin
      if (DATA_W < 2)    $error("DATA_W must be at least 2");
      if (ADDR_W < 3)    $error("ADDR_W must hold two word indices");
      if (PULSE_LEN < 1) $error("PULSE_LEN must be at least 1");
   end

   logic [DATA_W-1:0] count_q;
   logic              count_wr;
   wdt_opts_t         opts_q;
   logic              fire;
   logic              pulse_done;

   wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .count_q   (count_q),
      .count_wr  (count_wr),
      .opts_q    (opts_q),
      .bus_rdata (bus_rdata)
   );

   wdt_counter #(.DATA_W(DATA_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .opts_q     (opts_q),
      .tick_xtal  (tick_xtal),
      .tick_alt   (tick_alt),
      .count_wr   (count_wr),
      .wr_value   (bus_wdata),
      .pulse_busy (rst_req),
      .pulse_done (pulse_done),
      .count_q    (count_q),
      .fire       (fire)
   );

   wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .req   (rst_req),
      .done  (pulse_done)
   );

endmodule

// File: rtl/wdt_countdown_chk.sv
module wdt_countdown_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PULSE_LEN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] count,
   input logic              count_wr,
   input logic [DATA_W-1:0] wdata,
   input logic              freeze,
   input logic              use_xtal,
   input logic              tick_xtal,
   input logic              tick_alt,
   input logic              rst_req
);
   localparam int unsigned HW = $clog2(PULSE_LEN + 2);

   logic          sel;
   logic [HW-1:0] high_cycles;

   assign sel = use_xtal ? tick_xtal : tick_alt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       high_cycles <= '0;
      else if (rst_req) high_cycles <= high_cycles + HW'(1);
      else              high_cycles <= '0;
   end

   // R5
   parked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !count_wr) |=> (count == '0));

   // R5
   parked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !rst_req) |=> !rst_req);

   // R8
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !count_wr && !rst_req) |=> $stable(count));

   // R8
   frozen_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> !$past(freeze));

   // R6
   one_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == DATA_W'(1) && !freeze && !rst_req) |=> rst_req);

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count > DATA_W'(1) && sel && !freeze && !count_wr && !rst_req)
      |=> (count == $past(count) - DATA_W'(1)));

   // R9
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_wr |=> (count == $past(wdata)));

   // R7
   pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (high_cycles < HW'(PULSE_LEN)));

   // R7
   pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_req) |-> (high_cycles == HW'(PULSE_LEN)));

   // R7
   pulse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_req) && !$past(count_wr)) |-> (count == '0));

endmodule

bind wdt_countdown_top wdt_countdown_chk #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .count     (count_q),
   .count_wr  (count_wr),
   .wdata     (bus_wdata),
   .freeze    (opts_q.freeze),
   .use_xtal  (opts_q.use_xtal),
   .tick_xtal (tick_xtal),
   .tick_alt  (tick_alt),
   .rst_req   (rst_req)
);

// File: tb/test_wdt_countdown_top.sv
`timescale 1ns/1ps
module test_wdt_countdown_top;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 4;

   typedef struct {
      string       tag;
      logic [3:0]  addr;
      logic [31:0] exp_rd;
      logic        exp_rst;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              tick_xtal = 1'b0;
   logic              tick_alt = 1'b0;
   logic              rst_req;

   item_t exp_q[$];
   int    n_tests = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   always #2 clk = ~clk;

   wdt_countdown_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PULSE_LEN(4)) i_wdt_countdown_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_xtal (tick_xtal),
      .tick_alt  (tick_alt),
      .rst_req   (rst_req)
   );

   // monitor: pops one expectation per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         n_tests++;
         if (bus_rdata !== it.exp_rd || rst_req !== it.exp_rst) begin
            n_fail++;
            $display("FAIL %s addr=%0h: rdata=%h rst_req=%b, expected rdata=%h rst_req=%b",
                     it.tag, it.addr, bus_rdata, rst_req, it.exp_rd, it.exp_rst);
         end
      end
   end

   task automatic expect_rd(input logic [3:0] a, input logic [31:0] v,
                            input logic r, input string tag);
      item_t it;
      bus_addr = a;
      it.tag = tag; it.addr = a; it.exp_rd = v; it.exp_rst = r;
      exp_q.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] v);
      bus_addr = a; bus_wdata = v; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic ticks(input logic x, input logic al, input int n);
      for (int i = 0; i < n; i++) begin
         tick_xtal = x; tick_alt = al;
         @(posedge clk); #1;
      end
      tick_xtal = 1'b0; tick_alt = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);

      // R1 reset state
      expect_rd(4'h0, 32'h0, 1'b0, "R1 count after reset");
      expect_rd(4'h4, 32'h0, 1'b0, "R1 options after reset");

      // R2 register map and masking
      wr(4'h4, 32'hFFFF_FFFF);
      expect_rd(4'h4, 32'h8000_0001, 1'b0, "R2 option bits masked");
      wr(4'h4, 32'h0);
      wr(4'h8, 32'h0000_0005);
      expect_rd(4'h8, 32'h0, 1'b0, "R2 unmapped reads zero");
      expect_rd(4'h0, 32'h0, 1'b0, "R2 unmapped write ignored");

      // R3 / R4 countdown on alternate base
      wr(4'h0, 32'd10);
      expect_rd(4'h0, 32'd10, 1'b0, "R9 armed value reads back");
      ticks(1'b0, 1'b1, 3);
      expect_rd(4'h0, 32'd7, 1'b0, "R3 three alternate ticks");
      ticks(1'b1, 1'b0, 2);
      expect_rd(4'h0, 32'd7, 1'b0, "R4 crystal ticks ignored when bit0 clear");
      wr(4'h4, 32'h1);
      ticks(1'b1, 1'b0, 2);
      expect_rd(4'h0, 32'd5, 1'b0, "R4 crystal ticks used when bit0 set");
      ticks(1'b0, 1'b1, 2);
      expect_rd(4'h0, 32'd5, 1'b0, "R4 alternate ticks ignored when bit0 set");

      // R8 freeze
      wr(4'h4, 32'h8000_0001);
      ticks(1'b1, 1'b1, 3);
      expect_rd(4'h0, 32'd5, 1'b0, "R8 frozen count holds");
      wr(4'h0, 32'd1);
      idle(3);
      expect_rd(4'h0, 32'd1, 1'b0, "R8 frozen count of one raises nothing");
      wr(4'h4, 32'h1);
      expect_rd(4'h0, 32'd1, 1'b0, "R6 no request yet at unfreeze");
      idle(1);
      expect_rd(4'h0, 32'd1, 1'b1, "R6 request after unfreeze");
      idle(3);
      expect_rd(4'h0, 32'd1, 1'b1, "R7 request still high in cycle four");
      idle(1);
      expect_rd(4'h0, 32'd0, 1'b0, "R7 request ends and count clears");

      // R6 countdown reaching one
      wr(4'h0, 32'd3);
      ticks(1'b1, 1'b0, 1);
      expect_rd(4'h0, 32'd2, 1'b0, "R3 tick from three");
      ticks(1'b1, 1'b0, 1);
      expect_rd(4'h0, 32'd1, 1'b0, "R6 count at one, request follows");
      idle(1);
      expect_rd(4'h0, 32'd1, 1'b1, "R6 request after reaching one");
      idle(4);
      expect_rd(4'h0, 32'd0, 1'b0, "R7 pulse over, count zero");

      // R5 stopped state
      ticks(1'b1, 1'b1, 5);
      expect_rd(4'h0, 32'd0, 1'b0, "R5 ticks leave zero and no request");

      // R9 write beats tick, refresh, stop
      tick_xtal = 1'b1;
      wr(4'h0, 32'd20);
      tick_xtal = 1'b0;
      expect_rd(4'h0, 32'd20, 1'b0, "R9 write wins over tick");
      ticks(1'b1, 1'b0, 3);
      expect_rd(4'h0, 32'd17, 1'b0, "R3 running count");
      wr(4'h0, 32'd50);
      expect_rd(4'h0, 32'd50, 1'b0, "R9 refresh replaces count");
      wr(4'h0, 32'd0);
      ticks(1'b1, 1'b0, 3);
      expect_rd(4'h0, 32'd0, 1'b0, "R5 write zero stops");

      // R6 immediate restart by writing one
      wr(4'h0, 32'd1);
      expect_rd(4'h0, 32'd1, 1'b0, "R6 one written");
      idle(1);
      expect_rd(4'h0, 32'd1, 1'b1, "R6 immediate request");
      idle(5);
      expect_rd(4'h0, 32'd0, 1'b0, "R7 back to zero after restart pulse");

      idle(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule